// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block provides the pause function of a serial peripheral's SPI slave port. While the chip is selected, the host can drive the hold pin low to freeze the transfer. The block then blocks the serial clock and data path into the command logic and releases the data-out pin. When the hold pin returns high, the transfer continues from the bit where it stopped, because the shift state downstream never received a clock during the pause. An internal program, erase or status-write cycle is not affected, because the block only gates the serial interface.

All three pins are brought into a fast system clock through synchronizer chains. The system clock should run at least four times faster than the SPI clock. Hold is entered and left only while the synchronized serial clock is low. If the hold pin changes while the serial clock is high, the change takes effect at the next low phase of the serial clock. If chip select is released while the port is held, the port is reset into a lockout state. It becomes usable again only after the hold pin has returned high with chip select high, followed by a new falling edge of chip select.

Top module: `spi_hold_ctl`

## Requirements
- R1: After reset, hold_active is 0, clk_gate_en is 0 and do_oe_n is 1.
- R2: With cs_n low and hold_n high, clk_gate_en becomes 1 and do_oe_n becomes 0 no later than the third system clock edge after cs_n falls. The delay is two synchronizer stages plus one state register.
- R3: While selected, hold_n low with sck low makes hold_active 1 within three system clock edges.
- R4: While hold_active is 1, clk_gate_en is 0 and do_oe_n is 1, so the serial clock, data in and data out are all blocked.
- R5: If hold_n falls while sck is high, hold_active stays 0 for as long as sck stays high. It rises within three system clock edges after sck goes low.
- R6: While held, hold_n high with sck low clears hold_active and restores clk_gate_en to 1 and do_oe_n to 0.
- R7: If hold_n rises while sck is high during hold, the port stays held for as long as sck stays high. It resumes within three system clock edges after sck goes low.
- R8: If cs_n goes high while held, hold_active clears, clk_gate_en is 0 and do_oe_n is 1.
- R9: After R8, a new cs_n fall while hold_n is still low does not enable the port. The port is enabled only by a cs_n fall that follows a period with both hold_n and cs_n high.
- R10: If cs_n goes high while selected and not held, clk_gate_en returns to 0 and do_oe_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| hold_n | input | 1 | Hold pin, active low |
| hold_active | output | 1 | 1 while the transfer is paused |
| clk_gate_en | output | 1 | 1 lets sck and data in reach the command shifter |
| do_oe_n | output | 1 | 0 lets the data-out driver be enabled; 1 forces high impedance |

## Verification
The hardest case to reach is the lockout after chip select is released during a hold. The stimulus first enters hold. It then raises cs_n and drops cs_n again while hold_n is still low, and checks that the port stays closed. Only after that does it release hold_n, cycle cs_n and check the reopening. The deferred entry and deferred exit are reached by changing hold_n while sck is parked high for many system clocks, then lowering sck.

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic hold_active,
  output logic clk_gate_en,
  output logic do_oe_n
);

  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HELD, ST_LOCK} st_t;

  logic [TOP:0] sck_q, cs_q, hold_q;
  logic sck_s, cs_s, hold_s;
  st_t  st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      hold_q <= '1;
    end else begin
      sck_q  <= {sck_q[TOP-1:0], sck};
      cs_q   <= {cs_q[TOP-1:0], cs_n};
      hold_q <= {hold_q[TOP-1:0], hold_n};
    end
  end

  assign sck_s  = sck_q[TOP];
  assign cs_s   = cs_q[TOP];
  assign hold_s = hold_q[TOP];

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (!cs_s) st_nx = ST_RUN;
      ST_RUN: begin
        if (cs_s)                  st_nx = ST_IDLE;
        else if (!hold_s && !sck_s) st_nx = ST_HELD;
      end
      ST_HELD: begin
        if (cs_s)                  st_nx = ST_LOCK;
        else if (hold_s && !sck_s) st_nx = ST_RUN;
      end
      ST_LOCK: if (cs_s && hold_s) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign hold_active = (st == ST_HELD);
  assign clk_gate_en = (st == ST_RUN);
  assign do_oe_n     = (st != ST_RUN);

  // R3 R5
  enter_lowclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!sck_s && !hold_s && !cs_s));

  // R6 R7 R8
  exit_lowclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(cs_s || (hold_s && !sck_s)));

  // R9
  lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK && !hold_s) |=> (st == ST_LOCK && !clk_gate_en));

  // R10
  desel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !clk_gate_en);

  // R2
  open_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> $past(!cs_s));

endmodule

// File: tb/sim_spi_hold_ctl.sv
module sim_spi_hold_ctl;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic hold_active, clk_gate_en, do_oe_n;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  spi_hold_ctl u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .hold_n(hold_n), .hold_active(hold_active), .clk_gate_en(clk_gate_en),
    .do_oe_n(do_oe_n));

  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {hold_active, clk_gate_en, do_oe_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hold,gate,oe_n} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", 3'b001);
    rst_n = 1'b1; wait_n(5);
    chk("R1", 3'b001);
  endtask

  task automatic t_select;
    cs_n = 1'b0; wait_n(3);
    chk("R2", 3'b010);
  endtask

  task automatic t_hold_low_clk;
    sck = 1'b0; hold_n = 1'b0; wait_n(3);
    chk("R3", 3'b101);
    chk("R4", 3'b101);
    hold_n = 1'b1; wait_n(3);
    chk("R6", 3'b010);
  endtask

  task automatic t_hold_high_clk;
    sck = 1'b1; wait_n(2);
    hold_n = 1'b0; wait_n(10);
    chk("R5", 3'b010);
    sck = 1'b0; wait_n(3);
    chk("R5", 3'b101);
  endtask

  task automatic t_release_high_clk;
    sck = 1'b1; wait_n(10);
    chk("R4", 3'b101);
    hold_n = 1'b1; wait_n(10);
    chk("R7", 3'b101);
    sck = 1'b0; wait_n(3);
    chk("R7", 3'b010);
  endtask

  task automatic t_deselect_run;
    cs_n = 1'b1; wait_n(3);
    chk("R10", 3'b001);
  endtask

  task automatic t_deselect_held;
    cs_n = 1'b0; wait_n(4);
    chk("R2", 3'b010);
    hold_n = 1'b0; wait_n(4);
    chk("R3", 3'b101);
    cs_n = 1'b1; wait_n(4);
    chk("R8", 3'b001);
    cs_n = 1'b0; wait_n(10);
    chk("R9", 3'b001);
    hold_n = 1'b1; wait_n(10);
    chk("R9", 3'b001);
    cs_n = 1'b1; wait_n(4);
    chk("R9", 3'b001);
    cs_n = 1'b0; wait_n(4);
    chk("R9", 3'b010);
  endtask

  initial begin
    wait_n(3);
    t_reset;
    t_select;
    t_hold_low_clk;
    t_hold_high_clk;
    t_release_high_clk;
    t_deselect_run;
    t_deselect_held;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule